// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog peripheral on a small word-addressed register port. Once enabled it counts time in prescaled ticks through two cascaded stages. The first stage runs down from its own preload. When it expires it can latch an interrupt, and it then hands over to the second stage. The second stage runs down from a separate preload. When it expires the block pulses its reset output and records the event in a sticky timeout flag. Software keeps the system alive by sending a reload command, which puts the count back at the start of stage one.

The preload registers and the reload/flag register are guarded by a key handshake. Two key words must be written to the reload register, and only then is exactly one write to a guarded register taken. The control word holds three bits: enable, mode and lock. Once lock is set, enable cannot be cleared and the control word stays frozen until power-on reset. A timer mode turns stage one into a free-running periodic interrupt source and never reaches stage two.

The key handshake is the FSM `wdt_unlock`. Its states are KEY_IDLE, KEY_HALF and KEY_OPEN. Its transitions are: first key (IDLE to HALF), second key (HALF to OPEN), key repeat (HALF stays HALF), key break (HALF to IDLE), and consume (OPEN to IDLE on any guarded write). The stage sequencer is the FSM `wdt_stages`. Its states are ST_OFF, ST_RUN1, ST_RUN2 and ST_BITE. Its transitions are: start or reload (any state to RUN1), stop (to OFF), expire1 (RUN1 to RUN2), rearm (RUN1 to RUN1 in timer mode), expire2 (RUN2 to BITE), and restart (BITE to RUN1).

Top module: `wdt_top`

## Requirements
- R1: Register map (byte offsets): 0x00 reload/key, 0x04 stage-1 preload, 0x08 stage-2 preload, 0x0C interrupt status, 0x10 config, 0x14 control. The guarded registers are 0x00, 0x04 and 0x08. Writing the word 0x80 and then the word 0x86 to 0x00 lets exactly one later guarded write take effect. Preloads are CNT_W bits wide and read back as written.
- R2: A guarded write is ignored in three cases: when no key pair came first, when a write other than 0x86 or 0x80 breaks the pair, and when it is the second guarded write after one unlock.
- R3: An accepted reload-register write with bit 8 set, while enabled, restarts stage one from its preload and clears the prescaler. Reloads that arrive often enough keep the interrupt from ever rising.
- R4: Stage one expires on its N1-th tick. Expiry sets status bit 0, which drives `irq_o`, unless config bits 1:0 are 11. Writing 1 to status bit 0 clears it.
- R5: With config bit 5 = 0, stage two expires N2 ticks after stage one. At that point `wdt_rst_o` is high for exactly one cycle and stage one starts again. From the enabling write, `irq_o` rises after N1·P clock cycles and `wdt_rst_o` after (N1+N2)·P cycles. A preload of 0 acts as 1.
- R6: Reload-register bit 9 reads 1 after a reset caused by expiry. An accepted write with bit 9 set clears it. Writing 0x300 clears the flag and reloads in one access.
- R7: Control bit 1 is enable and bit 2 is mode (0 = watchdog). Setting enable starts stage one. Clearing enable while unlocked stops the count, so no interrupt follows. After reset every register reads 0 and both outputs are low.
- R8: Control bit 0 is lock. While lock is set, a write of 0 to the control register leaves it reading 0x3. Lock and the timeout flag survive `wdt_rst_o` and are cleared only by `rst_n`.
- R9: A tick is 2^SLOW_EXP clock cycles when config bit 2 = 0 and 2^FAST_EXP cycles when it is 1.
- R10: With mode = 1, stage one reloads itself on every expiry and raises the interrupt again. Stage two never runs and `wdt_rst_o` stays low.
- R11: With config bit 5 = 1, stage-two expiry leaves `wdt_rst_o` low and does not set the timeout flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Stage-one interrupt, level |
| wdt_rst_o | output | 1 | One-cycle reset request on stage-two expiry |

## Verification
The hardest conditions to reach from the ports are the exact expiry cycles and the half-open key states. Expiry is only seen after a prescaler, two preloads and the key handshake have all been set up. The bench therefore runs with a small fast-tick exponent and sweeps every stage-one/stage-two preload pair in a 3×3 grid. It counts cycles from the enabling write and compares them with N·P worked out arithmetically. The key FSM is driven into KEY_HALF and then broken with a foreign word. A second guarded write is tried after a consumed unlock. Lock persistence is shown by setting lock, trying to disable, and letting a full bite happen.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        KEY_IDLE,
        KEY_HALF,
        KEY_OPEN
    } key_state_t;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_RUN1,
        ST_RUN2,
        ST_BITE
    } stage_state_t;

    localparam logic [4:0] OFS_RELOAD = 5'h00;
    localparam logic [4:0] OFS_PRE1   = 5'h04;
    localparam logic [4:0] OFS_PRE2   = 5'h08;
    localparam logic [4:0] OFS_ISR    = 5'h0C;
    localparam logic [4:0] OFS_CFG    = 5'h10;
    localparam logic [4:0] OFS_CTRL   = 5'h14;

    localparam int KEY_FIRST  = 'h80;
    localparam int KEY_SECOND = 'h86;

    localparam int BIT_RELOAD  = 8;
    localparam int BIT_TOFLAG  = 9;
    localparam int BIT_LOCK    = 0;
    localparam int BIT_ENABLE  = 1;
    localparam int BIT_MODE    = 2;
    localparam int BIT_FAST    = 2;
    localparam int BIT_RSTDIS  = 5;

endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
    import wdt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_reload,
    input  logic              wr_guarded,
    input  logic [DATA_W-1:0] wdata,
    output logic              accept_o
);

    key_state_t state_q, state_d;
    logic is_first, is_second;

    assign is_first  = (wdata == DATA_W'(KEY_FIRST));
    assign is_second = (wdata == DATA_W'(KEY_SECOND));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KEY_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KEY_IDLE: begin
                if (wr_reload && is_first) state_d = KEY_HALF;
            end
            KEY_HALF: begin
                if (wr_reload && is_second)     state_d = KEY_OPEN;
                else if (wr_reload && is_first) state_d = KEY_HALF;
                else if (wr_guarded)            state_d = KEY_IDLE;
            end
            KEY_OPEN: begin
                if (wr_guarded) state_d = KEY_IDLE;
            end
            default: state_d = KEY_IDLE;
        endcase
    end

    always_comb begin
        accept_o = (state_q == KEY_OPEN) && wr_guarded;
    end

    // R1
    relock_after_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> (state_q == KEY_IDLE));

    // R2
    open_only_after_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == KEY_OPEN) |-> ($past(state_q) == KEY_HALF));

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int SLOW_EXP = 15,
    parameter int FAST_EXP = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    input  logic fast_sel,
    output logic tick_o
);

    logic [SLOW_EXP-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              div_q <= '0;
        else if (clear || !run)  div_q <= '0;
        else                     div_q <= div_q + 1'b1;
    end

    always_comb begin
        if (fast_sel) tick_o = run && (&div_q[FAST_EXP-1:0]);
        else          tick_o = run && (&div_q);
    end

    // R9
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/wdt_stages.sv
module wdt_stages
    import wdt_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             timer_mode,
    input  logic             tick,
    input  logic [CNT_W-1:0] pre1,
    input  logic [CNT_W-1:0] pre2,
    output logic             fire1_o,
    output logic             fire2_o,
    output logic             bite_o
);

    stage_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic at_end;

    assign at_end = tick && (cnt_q <= CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (restart) begin
            state_d = ST_RUN1;
            cnt_d   = pre1;
        end else if (!run) begin
            state_d = ST_OFF;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_d = ST_OFF;
                end
                ST_RUN1: begin
                    if (at_end && timer_mode) begin
                        state_d = ST_RUN1;
                        cnt_d   = pre1;
                    end else if (at_end) begin
                        state_d = ST_RUN2;
                        cnt_d   = pre2;
                    end else if (tick) begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                ST_RUN2: begin
                    if (at_end) begin
                        state_d = ST_BITE;
                        cnt_d   = '0;
                    end else if (tick) begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                ST_BITE: begin
                    state_d = ST_RUN1;
                    cnt_d   = pre1;
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    always_comb begin
        fire1_o = run && !restart && (state_q == ST_RUN1) && at_end;
        fire2_o = run && !restart && (state_q == ST_RUN2) && at_end;
        bite_o  = (state_q == ST_BITE);
    end

    // R5
    bite_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BITE) |=> (state_q != ST_BITE));

    // R3
    restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> ((state_q == ST_RUN1) && (cnt_q == $past(pre1))));

    // R10
    timer_no_stage2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_mode && run && (state_q == ST_RUN1)) |=> (state_q != ST_RUN2));

endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int CNT_W    = 20,
    parameter int SLOW_EXP = 15,
    parameter int FAST_EXP = 5,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              wdt_rst_o
);

    localparam int CFG_W = 6;

    logic [CNT_W-1:0] pre1_q, pre2_q;
    logic [CFG_W-1:0] cfg_q;
    logic lock_q, en_q, mode_q, isr_q, flag_q;

    logic wr_reload, wr_pre1, wr_pre2, wr_isr, wr_cfg, wr_ctrl, wr_guarded;
    logic accept, reload_cmd, flag_clr, en_start, restart;
    logic tick, fire1, fire2, bite;

    assign wr_reload  = bus_wr && (bus_addr == ADDR_W'(OFS_RELOAD));
    assign wr_pre1    = bus_wr && (bus_addr == ADDR_W'(OFS_PRE1));
    assign wr_pre2    = bus_wr && (bus_addr == ADDR_W'(OFS_PRE2));
    assign wr_isr     = bus_wr && (bus_addr == ADDR_W'(OFS_ISR));
    assign wr_cfg     = bus_wr && (bus_addr == ADDR_W'(OFS_CFG));
    assign wr_ctrl    = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_guarded = wr_reload || wr_pre1 || wr_pre2;

    wdt_unlock #(.DATA_W(DATA_W)) u_unlock (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_reload  (wr_reload),
        .wr_guarded (wr_guarded),
        .wdata      (bus_wdata),
        .accept_o   (accept)
    );

    assign reload_cmd = accept && wr_reload && bus_wdata[BIT_RELOAD];
    assign flag_clr   = accept && wr_reload && bus_wdata[BIT_TOFLAG];
    assign en_start   = wr_ctrl && bus_wdata[BIT_ENABLE] && !en_q;
    assign restart    = (reload_cmd && en_q) || en_start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre1_q <= '0;
            pre2_q <= '0;
        end else begin
            if (accept && wr_pre1) pre1_q <= bus_wdata[CNT_W-1:0];
            if (accept && wr_pre2) pre2_q <= bus_wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_cfg) begin
            cfg_q <= '0;
            cfg_q[BIT_RSTDIS] <= bus_wdata[BIT_RSTDIS];
            cfg_q[BIT_FAST]   <= bus_wdata[BIT_FAST];
            cfg_q[1:0]        <= bus_wdata[1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
            en_q   <= 1'b0;
            mode_q <= 1'b0;
        end else if (wr_ctrl) begin
            if (lock_q) begin
                en_q <= en_q | bus_wdata[BIT_ENABLE];
            end else begin
                lock_q <= bus_wdata[BIT_LOCK];
                en_q   <= bus_wdata[BIT_ENABLE];
                mode_q <= bus_wdata[BIT_MODE];
            end
        end
    end

    wdt_prescaler #(.SLOW_EXP(SLOW_EXP), .FAST_EXP(FAST_EXP)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (en_q),
        .clear    (restart),
        .fast_sel (cfg_q[BIT_FAST]),
        .tick_o   (tick)
    );

    wdt_stages #(.CNT_W(CNT_W)) u_stages (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (en_q),
        .restart    (restart),
        .timer_mode (mode_q),
        .tick       (tick),
        .pre1       (pre1_q),
        .pre2       (pre2_q),
        .fire1_o    (fire1),
        .fire2_o    (fire2),
        .bite_o     (bite)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            isr_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (fire1 && (cfg_q[1:0] != 2'b11)) isr_q <= 1'b1;
            else if (wr_isr && bus_wdata[0])    isr_q <= 1'b0;
            if (fire2 && !cfg_q[BIT_RSTDIS])    flag_q <= 1'b1;
            else if (flag_clr)                  flag_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_W'(OFS_RELOAD): bus_rdata[BIT_TOFLAG] = flag_q;
            ADDR_W'(OFS_PRE1):   bus_rdata[CNT_W-1:0]  = pre1_q;
            ADDR_W'(OFS_PRE2):   bus_rdata[CNT_W-1:0]  = pre2_q;
            ADDR_W'(OFS_ISR):    bus_rdata[0]          = isr_q;
            ADDR_W'(OFS_CFG):    bus_rdata[CFG_W-1:0]  = cfg_q;
            ADDR_W'(OFS_CTRL):   bus_rdata[2:0]        = {mode_q, en_q, lock_q};
            default:             bus_rdata             = '0;
        endcase
    end

    assign irq_o     = isr_q;
    assign wdt_rst_o = bite && !cfg_q[BIT_RSTDIS];

    // R8
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

    // R8
    enable_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && en_q) |=> en_q);

    // R6
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(fire2));

    // R4
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(isr_q) |-> ($past(cfg_q[1:0]) != 2'b11));

    // R11
    rst_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[BIT_RSTDIS] |-> !wdt_rst_o);

endmodule

// File: tb/tb_wdt_top.sv
module tb_wdt_top;

    localparam int CNT_W    = 20;
    localparam int SLOW_EXP = 6;
    localparam int FAST_EXP = 2;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 5;
    localparam int PF       = 1 << FAST_EXP;
    localparam int PS       = 1 << SLOW_EXP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic irq_o, wdt_rst_o;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    wdt_top #(.CNT_W(CNT_W), .SLOW_EXP(SLOW_EXP), .FAST_EXP(FAST_EXP),
              .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .wdt_rst_o(wdt_rst_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = DATA_W'(d);
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output int d);
        @(negedge clk);
        bus_addr = ADDR_W'(a);
        #1 d = int'(bus_rdata);
    endtask

    task automatic gwr(input logic [4:0] a, input int d);
        wr(5'h00, 'h80);
        wr(5'h00, 'h86);
        wr(a, d);
    endtask

    task automatic wait_for(input bit want_rst, input int limit, output int cyc);
        cyc = 0;
        while (!(want_rst ? wdt_rst_o : irq_o) && cyc < limit) begin
            @(posedge clk); #1 cyc++;
        end
        if (!(want_rst ? wdt_rst_o : irq_o)) cyc = -1;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int d, c1, c2, seen;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R7 reset state
        for (int a = 0; a < 6; a++) begin
            rd(5'(a * 4), d);
            check("R7 reset read", d, 0);
        end
        check("R7 reset irq", irq_o, 0);
        check("R7 reset rst", wdt_rst_o, 0);

        // R2 no unlock
        wr(5'h04, 5); rd(5'h04, d); check("R2 no key", d, 0);
        // R1 unlock then one write
        gwr(5'h04, 5); rd(5'h04, d); check("R1 preload1", d, 5);
        wr(5'h04, 7); rd(5'h04, d); check("R2 second write", d, 5);
        // R2 broken pair
        wr(5'h00, 'h80); wr(5'h00, 'h55); wr(5'h00, 'h86); wr(5'h08, 3);
        rd(5'h08, d); check("R2 broken key", d, 0);
        gwr(5'h08, 'hFFFFF); rd(5'h08, d); check("R1 preload2 width", d, 'hFFFFF);

        // R5 R9 sweep with fast tick
        wr(5'h10, 'h04);
        for (int n1 = 1; n1 <= 3; n1++) begin
            for (int n2 = 1; n2 <= 3; n2++) begin
                wr(5'h14, 0);
                wr(5'h0C, 1);
                gwr(5'h04, n1);
                gwr(5'h08, n2);
                wr(5'h14, 'h2);
                wait_for(1'b0, 200, c1);
                check("R4 R9 irq cycles", c1, n1 * PF);
                wait_for(1'b1, 200, c2);
                check("R5 rst cycles", c2, n2 * PF);
            end
        end
        wr(5'h14, 0);
        rd(5'h00, d); check("R6 flag set", d, 'h200);
        gwr(5'h00, 'h300); rd(5'h00, d); check("R6 flag cleared", d, 0);
        wr(5'h0C, 1); rd(5'h0C, d); check("R4 w1c", d, 0);

        // R5 preload zero acts as one
        gwr(5'h04, 0); gwr(5'h08, 0);
        wr(5'h14, 'h2);
        wait_for(1'b0, 200, c1); check("R5 zero preload irq", c1, PF);
        wait_for(1'b1, 200, c2); check("R5 zero preload rst", c2, PF);
        wr(5'h14, 0); gwr(5'h00, 'h200); wr(5'h0C, 1);

        // R11 reset output disabled
        wr(5'h10, 'h24);
        gwr(5'h04, 1); gwr(5'h08, 1);
        wr(5'h14, 'h2);
        seen = 0;
        for (int i = 0; i < 8 * PF; i++) begin
            @(posedge clk); #1 if (wdt_rst_o) seen = 1;
        end
        check("R11 no rst", seen, 0);
        check("R11 irq still", irq_o, 1);
        wr(5'h14, 0);
        rd(5'h00, d); check("R11 no flag", d, 0);
        wr(5'h0C, 1);

        // R4 interrupt disabled, reset still happens
        wr(5'h10, 'h07);
        wr(5'h14, 'h2);
        wait_for(1'b1, 200, c2);
        check("R4 masked rst cycles", c2, 2 * PF);
        check("R4 masked irq", irq_o, 0);
        wr(5'h14, 0); gwr(5'h00, 'h200);

        // R7 disable stops the count
        wr(5'h10, 'h04);
        gwr(5'h04, 3);
        wr(5'h14, 'h2);
        wr(5'h14, 0);
        wait_for(1'b0, 6 * PF, c1);
        check("R7 stopped", c1, -1);

        // R3 keepalive
        wr(5'h14, 'h2);
        seen = 0;
        for (int i = 0; i < 6; i++) begin
            gwr(5'h00, 'h100);
            repeat (5) @(posedge clk);
            #1 if (irq_o) seen = 1;
        end
        check("R3 kept alive", seen, 0);
        gwr(5'h00, 'h100);
        wait_for(1'b0, 200, c1);
        check("R3 after last reload", c1, 3 * PF);
        wr(5'h14, 0); wr(5'h0C, 1);

        // R10 timer mode
        gwr(5'h04, 2);
        wr(5'h14, 'h6);
        wait_for(1'b0, 200, c1);
        check("R10 first irq", c1, 2 * PF);
        wr(5'h0C, 1);
        wait_for(1'b0, 200, c1);
        check("R10 repeat irq", c1 > 0, 1);
        seen = 0;
        for (int i = 0; i < 8 * PF; i++) begin
            @(posedge clk); #1 if (wdt_rst_o) seen = 1;
        end
        check("R10 no rst", seen, 0);
        wr(5'h14, 0); wr(5'h0C, 1);

        // R9 slow tick
        wr(5'h10, 'h00);
        gwr(5'h04, 1);
        wr(5'h14, 'h2);
        wait_for(1'b0, 400, c1);
        check("R9 slow irq", c1, PS);
        wr(5'h14, 0); wr(5'h0C, 1);

        // R8 lock
        wr(5'h10, 'h04);
        gwr(5'h08, 1);
        wr(5'h14, 'h3);
        wr(5'h14, 0);
        rd(5'h14, d); check("R8 lock holds enable", d, 3);
        wait_for(1'b1, 200, c2);
        check("R8 rst while locked", c2 > 0, 1);
        @(posedge clk); #1;
        rd(5'h14, d); check("R8 lock after bite", d, 3);
        rd(5'h00, d); check("R8 flag after bite", d, 'h200);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule